// File: doc/BRIEF.md
# Per-Thread Interrupt Presenter Context

This block is the interrupt context that an interrupt presenter keeps for one CPU thread. It holds two priority rings: a guest-OS ring and a hypervisor physical ring. Each ring has an 8-bit pending buffer, a current processor priority, a derived pending priority and a status byte. The block also holds a pool-ring context word and a hypervisor context byte. When a ring's most urgent pending priority beats the priority the thread is running at, the block records the exception in that ring's status byte and raises a single interrupt line toward the core.

Software reaches the context through a byte-offset load/store port. Each access carries a page select (OS or HV), an offset, a size in bytes and a direction. A small set of accesses has side effects. These are acknowledging an interrupt, changing a ring's priority, pushing or polling the hypervisor context byte, and pulling (read-and-clear) the pool context. An access is treated as special only when page, offset, size and direction all match. Any other access falls through to plain register handling. Load data is combinational in the cycle of the access, and every state change lands at the following clock edge.

Top module: `irq_thread_ctx`

## Requirements
- R1: A ring notifies only when, after a write of its current priority (CPPR) or of its pending buffer (IPB), its pending priority (PIPR) is numerically below its CPPR. A notification sets `irq` at the next clock edge. `irq` stays high until an acknowledge.
- R2: A notification on the OS ring ORs 0x80 into the OS status byte (exception-occurred flag in bit 7).
- R3: A notification on the HV ring writes exception code 2'b01 (physical) into bits 7:6 of the HV status byte, giving 0x40. Codes 2'b10 and 2'b11 never appear, and bits 5:0 stay zero.
- R4: A 1-byte store with the HV page at offset 0x031 loads the HV CPPR from wdata[7:0]. A 1-byte store with the OS page at 0x011 loads the OS CPPR the same way. A store to 0x031 from the OS page has no effect.
- R5: A 2-byte load at 0x830 on the HV page (or at 0x810 on the OS page) returns {status, CPPR} of that ring in rdata[15:0]. At the next edge, CPPR takes the old PIPR, that priority's pending bit clears, PIPR is recomputed, the status byte becomes 0 and `irq` drops.
- R6: A 4-byte or 8-byte load at 0x838 on the HV page returns pool word & 0x3FFFFFFF. The same access clears bits 29:0 of the pool word and keeps bits 31:30.
- R7: A 1-byte store on the HV page at 0x038 keeps wdata[7:0] as the HV context byte. A 1-byte load at 0x038 returns it.
- R8: After reset, every status, CPPR and pending buffer is 0, each PIPR is 0xFF, the pool word and context byte are 0, and `irq` is low.
- R9: In the pending buffer, bit 7-p marks priority p as pending. PIPR is the lowest-numbered pending priority, or 0xFF when none is pending. A 1-byte store at 0x012 (OS) or 0x032 (HV) writes the buffer.
- R10: An access whose size, page or direction differs from a special entry has no side effect. Examples are a 4-byte load at 0x830, or a 2-byte load at 0x830 on the OS page. Such an access returns 0.
- R11: Plain stores into HV-ring state (0x032, 0x038) or into the pool word (4-byte store at 0x028) take effect only on the HV page. From the OS page they are dropped.
- R12: A plain 1-byte load returns a ring field: status at +0, CPPR at +1, buffer at +2 and PIPR at +3, from ring bases 0x010 (OS) and 0x030 (HV). A 4-byte load at 0x028 returns the whole pool word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe, one access per cycle |
| acc_page | input | 1 | Page select: 0 = OS, 1 = HV |
| acc_offset | input | 12 | Byte offset of the access |
| acc_size | input | 4 | Access size in bytes (1, 2, 4, 8) |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_wdata | input | 64 | Store data |
| acc_rdata | output | 64 | Load data, valid in the access cycle |
| irq | output | 1 | Interrupt line to the thread |

## Verification
The assertions check the following on every cycle:
- At most one side-effect operation is decoded per access.
- A status byte only changes away from zero while PIPR is below CPPR.
- Neither status byte ever holds a bit outside its own exception mask, so HV codes other than physical never appear.
- An acknowledge always leaves the status clear, CPPR equal to the old PIPR, and the line low.
- A pull always leaves the pool field clear.
- A raised line always has a status byte behind it.

Only the bench scenarios can show the arithmetic results. These are the pending-priority encoding swept over every buffer value, the notify decision across every priority pair, the exact acknowledge return words, and the fact that mismatched or wrong-page accesses leave state untouched.

// File: rtl/ictx_pkg.sv
// Package: shared widths, address map, decode types and priority helpers
// for the per-thread interrupt context. Assumes 8 priority levels held in
// an 8-bit pending buffer where bit (7-p) marks priority p.
package ictx_pkg;
    localparam int PRIO_W  = 8;
    localparam int NPRIO   = 8;
    localparam int OFF_W   = 12;
    localparam int SZ_W    = 4;
    localparam int DATA_W  = 64;
    localparam int POOL_W  = 32;
    localparam int CAM_W   = 30;
    localparam int NRING   = 2;
    localparam int RING_OS = 0;
    localparam int RING_HV = 1;

    localparam logic [PRIO_W-1:0] PRIO_NONE = '1;
    localparam logic [PRIO_W-1:0] OS_EXC    = 8'h80;
    localparam logic [PRIO_W-1:0] HV_EXC    = 8'h40;
    localparam logic [POOL_W-1:0] CAM_MASK  = POOL_W'((64'd1 << CAM_W) - 64'd1);

    localparam logic PAGE_OS = 1'b0;
    localparam logic PAGE_HV = 1'b1;

    localparam logic [OFF_W-1:0] OS_BASE  = 12'h010;
    localparam logic [OFF_W-1:0] POOL_W2  = 12'h028;
    localparam logic [OFF_W-1:0] HV_BASE  = 12'h030;
    localparam logic [OFF_W-1:0] F_NSR    = 12'h000;
    localparam logic [OFF_W-1:0] F_CPPR   = 12'h001;
    localparam logic [OFF_W-1:0] F_IPB    = 12'h002;
    localparam logic [OFF_W-1:0] F_PIPR   = 12'h003;
    localparam logic [OFF_W-1:0] F_W2     = 12'h008;
    localparam logic [OFF_W-1:0] OS_ACK   = 12'h810;
    localparam logic [OFF_W-1:0] HV_ACK   = 12'h830;
    localparam logic [OFF_W-1:0] POOL_PULL = 12'h838;

    typedef enum logic [2:0] {
        RD_NONE, RD_BYTE, RD_ACK_OS, RD_ACK_HV, RD_POOL, RD_PULL, RD_HVW2
    } rd_kind_e;

    typedef struct packed {
        logic os_cppr_wr;
        logic hv_cppr_wr;
        logic os_buf_wr;
        logic hv_buf_wr;
        logic os_ack;
        logic hv_ack;
        logic hv_push;
        logic pool_wr;
        logic pool_pull;
    } op_t;

    // Lowest-numbered pending priority, or PRIO_NONE when the buffer is empty.
    function automatic logic [PRIO_W-1:0] buf_to_prio(input logic [NPRIO-1:0] b);
        logic [PRIO_W-1:0] r;
        r = PRIO_NONE;
        for (int p = NPRIO - 1; p >= 0; p--) begin
            if (b[NPRIO-1-p]) r = PRIO_W'(p);
        end
        return r;
    endfunction

    // Pending-buffer bit that stands for priority p (zero when p is out of range).
    function automatic logic [NPRIO-1:0] prio_bit(input logic [PRIO_W-1:0] p);
        logic [NPRIO-1:0] m;
        m = '0;
        for (int i = 0; i < NPRIO; i++) begin
            if (p == PRIO_W'(i)) m[NPRIO-1-i] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ictx_decode.sv
// Access decoder: classifies one load/store by page, offset, size and
// direction. Special entries need all four to match; anything else falls
// to plain register handling, which only writes HV state from the HV page.
// Assumes at most one access per cycle.
module ictx_decode
    import ictx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid,
    input  logic             page,
    input  logic [OFF_W-1:0] offset,
    input  logic [SZ_W-1:0]  size,
    input  logic             write,
    output op_t              op,
    output rd_kind_e         rd_kind
);
    logic sz1, sz2, sz48, hv_pg, os_pg, rd, wr;
    logic is_ring_byte;

    assign sz1   = (size == SZ_W'(1));
    assign sz2   = (size == SZ_W'(2));
    assign sz48  = (size == SZ_W'(4)) || (size == SZ_W'(8));
    assign hv_pg = (page == PAGE_HV);
    assign os_pg = (page == PAGE_OS);
    assign rd    = valid && !write;
    assign wr    = valid && write;

    // Offsets readable as plain single bytes.
    always_comb begin
        is_ring_byte = 1'b0;
        for (int f = 0; f < 4; f++) begin
            if (offset == OS_BASE + OFF_W'(f)) is_ring_byte = 1'b1;
            if (offset == HV_BASE + OFF_W'(f)) is_ring_byte = 1'b1;
        end
        if (offset == HV_BASE + F_W2) is_ring_byte = 1'b1;
    end

    // Priority decode: special entries first, then plain handling.
    always_comb begin
        op      = '0;
        rd_kind = RD_NONE;
        if (wr && sz1 && os_pg && offset == OS_BASE + F_CPPR) begin
            op.os_cppr_wr = 1'b1;
        end else if (wr && sz1 && hv_pg && offset == HV_BASE + F_CPPR) begin
            op.hv_cppr_wr = 1'b1;
        end else if (wr && sz1 && hv_pg && offset == HV_BASE + F_W2) begin
            op.hv_push = 1'b1;
        end else if (rd && sz1 && hv_pg && offset == HV_BASE + F_W2) begin
            rd_kind = RD_HVW2;
        end else if (rd && sz2 && os_pg && offset == OS_ACK) begin
            op.os_ack = 1'b1;
            rd_kind   = RD_ACK_OS;
        end else if (rd && sz2 && hv_pg && offset == HV_ACK) begin
            op.hv_ack = 1'b1;
            rd_kind   = RD_ACK_HV;
        end else if (rd && sz48 && hv_pg && offset == POOL_PULL) begin
            op.pool_pull = 1'b1;
            rd_kind      = RD_PULL;
        end else if (wr && sz1 && offset == OS_BASE + F_IPB) begin
            op.os_buf_wr = 1'b1;
        end else if (wr && sz1 && hv_pg && offset == HV_BASE + F_IPB) begin
            op.hv_buf_wr = 1'b1;
        end else if (wr && (size == SZ_W'(4)) && hv_pg && offset == POOL_W2) begin
            op.pool_wr = 1'b1;
        end else if (rd && sz1 && is_ring_byte) begin
            rd_kind = RD_BYTE;
        end else if (rd && (size == SZ_W'(4)) && offset == POOL_W2) begin
            rd_kind = RD_POOL;
        end
    end

    // R10: a single access never triggers two side effects.
    a_r10_one_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op));
    // R10: an idle port decodes nothing.
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> (op == '0 && rd_kind == RD_NONE));
endmodule

// File: rtl/ictx_ring.sv
// One priority ring: pending buffer, current priority, pending priority and
// status byte. Runs the notify check whenever CPPR or the buffer is written
// and performs the acknowledge sequence. Assumes callers strobe at most one
// of set_cppr, set_buf and accept per cycle.
module ictx_ring
    import ictx_pkg::*;
#(
    parameter logic [PRIO_W-1:0] EXC_MASK = OS_EXC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_cppr,
    input  logic              set_buf,
    input  logic              accept,
    input  logic [PRIO_W-1:0] wval,
    output logic [PRIO_W-1:0] nsr,
    output logic [PRIO_W-1:0] cppr,
    output logic [NPRIO-1:0]  ipb,
    output logic [PRIO_W-1:0] pipr,
    output logic              fire
);
    logic [PRIO_W-1:0] nsr_q, cppr_q, pipr_q, nx_nsr, nx_cppr, nx_pipr;
    logic [NPRIO-1:0]  buf_q, nx_buf;

    // Next-state for priority, buffer and status, including the notify decision.
    always_comb begin
        nx_cppr = cppr_q;
        nx_buf  = buf_q;
        if (set_cppr)    nx_cppr = wval;
        else if (accept) nx_cppr = pipr_q;
        if (set_buf)     nx_buf = wval[NPRIO-1:0];
        else if (accept) nx_buf = buf_q & ~prio_bit(pipr_q);
        nx_pipr = buf_to_prio(nx_buf);
        fire    = (set_cppr || set_buf) && (nx_pipr < nx_cppr);
        if (accept)    nx_nsr = '0;
        else if (fire) nx_nsr = nsr_q | EXC_MASK;
        else           nx_nsr = nsr_q;
    end

    // Ring state registers; reset recomputes PIPR from the cleared buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsr_q  <= '0;
            cppr_q <= '0;
            buf_q  <= '0;
            pipr_q <= buf_to_prio('0);
        end else begin
            nsr_q  <= nx_nsr;
            cppr_q <= nx_cppr;
            buf_q  <= nx_buf;
            pipr_q <= nx_pipr;
        end
    end

    assign nsr  = nsr_q;
    assign cppr = cppr_q;
    assign ipb  = buf_q;
    assign pipr = pipr_q;

    // R1: status only turns nonzero while the pending priority beats CPPR.
    a_r1_status_needs_order: assert property (@(posedge clk) disable iff (!rst_n)
        (nsr_q != '0 && $past(nsr_q) == '0) |-> (pipr_q < cppr_q));
    // R3: status byte holds no bit outside this ring's exception code.
    a_r3_status_in_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (nsr_q & ~EXC_MASK) == '0);
    // R5: acknowledge clears status and lifts CPPR to the old PIPR.
    a_r5_accept_result: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (nsr_q == '0 && cppr_q == $past(pipr_q)));
endmodule

// File: rtl/ictx_ctx_words.sv
// Context words: the pool-ring word (with its read-and-clear CAM field) and
// the hypervisor context byte. Assumes decode never strobes pool_wr and
// pool_pull together.
module ictx_ctx_words
    import ictx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pool_wr,
    input  logic              pool_pull,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    output logic [POOL_W-1:0] pool_word,
    output logic [PRIO_W-1:0] hv_byte
);
    logic [POOL_W-1:0] pool_q;
    logic [PRIO_W-1:0] hvb_q;

    // Pool word: plain write or clear of the CAM field on a pull.
    always_ff @(posedge clk) begin
        if (!rst_n)         pool_q <= '0;
        else if (pool_wr)   pool_q <= wdata[POOL_W-1:0];
        else if (pool_pull) pool_q <= pool_q & ~CAM_MASK;
    end

    // Hypervisor context byte: keeps the low byte of a push.
    always_ff @(posedge clk) begin
        if (!rst_n)    hvb_q <= '0;
        else if (push) hvb_q <= wdata[PRIO_W-1:0];
    end

    assign pool_word = pool_q;
    assign hv_byte   = hvb_q;

    // R6: a pull leaves the CAM field empty and the upper bits untouched.
    a_r6_pull_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pool_pull |=> ((pool_q & CAM_MASK) == '0 &&
                       (pool_q & ~CAM_MASK) == ($past(pool_q) & ~CAM_MASK)));
    // R7: a push is held as the context byte.
    a_r7_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (hvb_q == $past(wdata[PRIO_W-1:0])));
endmodule

// File: rtl/irq_thread_ctx.sv
// Top: per-thread interrupt presenter context. Decodes the access port,
// drives the two rings and context words, muxes load data and owns the
// single interrupt line. Assumes one access per cycle; load data is
// combinational, state changes land at the next edge.
module irq_thread_ctx
    import ictx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_page,
    input  logic [OFF_W-1:0]  acc_offset,
    input  logic [SZ_W-1:0]   acc_size,
    input  logic              acc_write,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              irq
);
    op_t      op;
    rd_kind_e rd_kind;

    logic [NRING-1:0]             set_cppr, set_buf, accept, fire;
    logic [NRING-1:0][PRIO_W-1:0] nsr_a, cppr_a, pipr_a;
    logic [NRING-1:0][NPRIO-1:0]  ipb_a;
    logic [POOL_W-1:0]            pool_word;
    logic [PRIO_W-1:0]            hv_byte;
    logic                         irq_q;
    logic [PRIO_W-1:0]            byte_val;

    ictx_decode u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid   (acc_valid),
        .page    (acc_page),
        .offset  (acc_offset),
        .size    (acc_size),
        .write   (acc_write),
        .op      (op),
        .rd_kind (rd_kind)
    );

    assign set_cppr[RING_OS] = op.os_cppr_wr;
    assign set_cppr[RING_HV] = op.hv_cppr_wr;
    assign set_buf[RING_OS]  = op.os_buf_wr;
    assign set_buf[RING_HV]  = op.hv_buf_wr;
    assign accept[RING_OS]   = op.os_ack;
    assign accept[RING_HV]   = op.hv_ack;

    for (genvar g = 0; g < NRING; g++) begin : g_ring
        ictx_ring #(
            .EXC_MASK ((g == RING_HV) ? HV_EXC : OS_EXC)
        ) u_ring (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_cppr (set_cppr[g]),
            .set_buf  (set_buf[g]),
            .accept   (accept[g]),
            .wval     (acc_wdata[PRIO_W-1:0]),
            .nsr      (nsr_a[g]),
            .cppr     (cppr_a[g]),
            .ipb      (ipb_a[g]),
            .pipr     (pipr_a[g]),
            .fire     (fire[g])
        );
    end

    ictx_ctx_words u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .pool_wr   (op.pool_wr),
        .pool_pull (op.pool_pull),
        .push      (op.hv_push),
        .wdata     (acc_wdata),
        .pool_word (pool_word),
        .hv_byte   (hv_byte)
    );

    // Interrupt line: an acknowledge lowers it, any notification raises it.
    always_ff @(posedge clk) begin
        if (!rst_n)             irq_q <= 1'b0;
        else if (|accept)       irq_q <= 1'b0;
        else if (|fire)         irq_q <= 1'b1;
    end
    assign irq = irq_q;

    // Plain byte select by offset across both rings and the context byte.
    always_comb begin
        byte_val = '0;
        for (int r = 0; r < NRING; r++) begin
            logic [OFF_W-1:0] base;
            base = (r == RING_HV) ? HV_BASE : OS_BASE;
            if (acc_offset == base + F_NSR)  byte_val = nsr_a[r];
            if (acc_offset == base + F_CPPR) byte_val = cppr_a[r];
            if (acc_offset == base + F_IPB)  byte_val = PRIO_W'(ipb_a[r]);
            if (acc_offset == base + F_PIPR) byte_val = pipr_a[r];
        end
        if (acc_offset == HV_BASE + F_W2) byte_val = hv_byte;
    end

    // Load data mux by decoded read kind.
    always_comb begin
        unique case (rd_kind)
            RD_BYTE:   acc_rdata = DATA_W'(byte_val);
            RD_ACK_OS: acc_rdata = DATA_W'({nsr_a[RING_OS], cppr_a[RING_OS]});
            RD_ACK_HV: acc_rdata = DATA_W'({nsr_a[RING_HV], cppr_a[RING_HV]});
            RD_POOL:   acc_rdata = DATA_W'(pool_word);
            RD_PULL:   acc_rdata = DATA_W'(pool_word & CAM_MASK);
            RD_HVW2:   acc_rdata = DATA_W'(hv_byte);
            default:   acc_rdata = '0;
        endcase
    end

    // R5: an acknowledge always leaves the line low.
    a_r5_ack_drops_line: assert property (@(posedge clk) disable iff (!rst_n)
        (|accept) |=> !irq_q);
    // R1: a raised line is always backed by a ring status byte.
    a_r1_line_has_status: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> ((nsr_a[RING_OS] | nsr_a[RING_HV]) != '0));
    // R1: the line only rises after a ring notification.
    a_r1_rise_needs_fire: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_q && !$past(irq_q)) |-> $past(|fire));
endmodule

// File: tb/tb_irq_thread_ctx.sv
`timescale 1ns/1ps
module tb_irq_thread_ctx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_page = 1'b0;
    logic [11:0] acc_offset = '0;
    logic [3:0]  acc_size = '0;
    logic        acc_write = 1'b0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] acc_rdata;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    irq_thread_ctx dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_page(acc_page),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_write(acc_write),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .irq(irq)
    );

    localparam logic OS = 1'b0;
    localparam logic HV = 1'b1;

    function automatic logic [7:0] exp_prio(input logic [7:0] b);
        for (int p = 0; p < 8; p++) if (b[7-p]) return 8'(p);
        return 8'hFF;
    endfunction

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    // One access; load data sampled mid-cycle, returns just after the edge.
    task automatic acc(input logic pg, input logic [11:0] off, input logic [3:0] sz,
                       input logic wr, input logic [63:0] wd, output logic [63:0] rd);
        @(negedge clk);
        acc_valid = 1'b1; acc_page = pg; acc_offset = off;
        acc_size = sz; acc_write = wr; acc_wdata = wd;
        #1 rd = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic st(input logic pg, input logic [11:0] off, input logic [3:0] sz,
                      input logic [63:0] wd);
        logic [63:0] d;
        acc(pg, off, sz, 1'b1, wd, d);
    endtask

    task automatic ld(input logic pg, input logic [11:0] off, input logic [3:0] sz,
                      output logic [63:0] rd);
        acc(pg, off, sz, 1'b0, 64'd0, rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [63:0] d;
        logic [7:0]  cps [11];
        for (int i = 0; i < 10; i++) cps[i] = 8'(i);
        cps[10] = 8'hFF;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 / R12: reset values of every ring byte and the line
        for (int r = 0; r < 2; r++) begin
            logic [11:0] b;
            b = (r == 0) ? 12'h010 : 12'h030;
            ld(OS, b + 12'd0, 4'd1, d); check("R8 status reset", d, 64'h0);
            ld(OS, b + 12'd1, 4'd1, d); check("R8 cppr reset", d, 64'h0);
            ld(OS, b + 12'd2, 4'd1, d); check("R8 buffer reset", d, 64'h0);
            ld(OS, b + 12'd3, 4'd1, d); check("R8 pipr reset", d, 64'hFF);
        end
        ld(HV, 12'h028, 4'd4, d); check("R8 pool reset", d, 64'h0);
        ld(HV, 12'h038, 4'd1, d); check("R8 context byte reset", d, 64'h0);
        check("R8 irq reset", {63'd0, irq}, 64'd0);

        // R9 / R12: every buffer value on both rings, CPPR 0 so no notify
        for (int b = 0; b < 256; b++) begin
            st(OS, 12'h012, 4'd1, 64'(b));
            ld(OS, 12'h013, 4'd1, d); check("R9 os pipr", d, 64'(exp_prio(8'(b))));
            ld(OS, 12'h012, 4'd1, d); check("R12 os buffer readback", d, 64'(b));
            st(HV, 12'h032, 4'd1, 64'(b));
            ld(HV, 12'h033, 4'd1, d); check("R9 hv pipr", d, 64'(exp_prio(8'(b))));
        end
        check("R1 no notify at cppr 0", {63'd0, irq}, 64'd0);

        // R1 / R2 / R3 / R5: every CPPR against every single pending priority
        for (int r = 0; r < 2; r++) begin
            logic        pg;
            logic [11:0] base, ackoff;
            logic [7:0]  mask;
            pg     = (r == 0) ? OS : HV;
            base   = (r == 0) ? 12'h010 : 12'h030;
            ackoff = (r == 0) ? 12'h810 : 12'h830;
            mask   = (r == 0) ? 8'h80 : 8'h40;
            for (int c = 0; c < 11; c++) begin
                for (int p = 0; p < 8; p++) begin
                    logic fire_e;
                    fire_e = (8'(p) < cps[c]);
                    st(pg, base + 12'd2, 4'd1, 64'd0);
                    ld(pg, ackoff, 4'd2, d);
                    st(pg, base + 12'd1, 4'd1, 64'(cps[c]));
                    st(pg, base + 12'd2, 4'd1, 64'(8'h80 >> p));
                    check("R1 irq after buffer write", {63'd0, irq}, {63'd0, fire_e});
                    ld(pg, base, 4'd1, d);
                    check(r == 0 ? "R2 os status" : "R3 hv status code", d,
                          fire_e ? 64'(mask) : 64'd0);
                    ld(pg, ackoff, 4'd2, d);
                    check("R5 ack word", d, {48'd0, (fire_e ? mask : 8'h00), cps[c]});
                    check("R5 irq after ack", {63'd0, irq}, 64'd0);
                    ld(pg, base + 12'd1, 4'd1, d); check("R5 cppr takes pipr", d, 64'(p));
                    ld(pg, base + 12'd2, 4'd1, d); check("R5 bit cleared", d, 64'd0);
                    ld(pg, base + 12'd3, 4'd1, d); check("R5 pipr recomputed", d, 64'hFF);
                    ld(pg, base, 4'd1, d);         check("R5 status cleared", d, 64'd0);
                end
            end
        end

        // R5: ack with two pending keeps the other one pending
        st(OS, 12'h011, 4'd1, 64'd0);
        st(OS, 12'h012, 4'd1, 64'h24);
        ld(OS, 12'h810, 4'd2, d); check("R5 ack two pending word", d, 64'h0000);
        ld(OS, 12'h012, 4'd1, d); check("R5 remaining buffer", d, 64'h04);
        ld(OS, 12'h013, 4'd1, d); check("R5 remaining pipr", d, 64'd5);

        // R1: lowering the priority bar via a CPPR write notifies
        st(OS, 12'h011, 4'd1, 64'd0);
        st(OS, 12'h012, 4'd1, 64'h10);
        check("R1 no notify at cppr 0", {63'd0, irq}, 64'd0);
        st(OS, 12'h011, 4'd1, 64'd5);
        check("R1 cppr write notifies", {63'd0, irq}, 64'd1);
        ld(OS, 12'h010, 4'd1, d); check("R2 status on cppr notify", d, 64'h80);
        ld(OS, 12'h810, 4'd2, d); check("R5 ack after cppr notify", d, 64'h8005);

        // R4 / R11: HV CPPR store only from the HV page, low byte only
        st(HV, 12'h031, 4'd1, 64'd0);
        st(OS, 12'h031, 4'd1, 64'h55);
        ld(HV, 12'h031, 4'd1, d); check("R4 os page cppr store dropped", d, 64'd0);
        st(HV, 12'h031, 4'd1, 64'h1234);
        ld(HV, 12'h031, 4'd1, d); check("R4 hv cppr low byte", d, 64'h34);
        st(OS, 12'h011, 4'd1, 64'hA7);
        ld(OS, 12'h011, 4'd1, d); check("R4 os cppr store", d, 64'hA7);
        st(HV, 12'h032, 4'd1, 64'd0);
        st(OS, 12'h032, 4'd1, 64'hFF);
        ld(HV, 12'h032, 4'd1, d); check("R11 os page buffer store dropped", d, 64'd0);
        check("R11 no irq from dropped store", {63'd0, irq}, 64'd0);

        // R10: mismatched accesses at the HV ack address have no effect
        st(HV, 12'h031, 4'd1, 64'd7);
        st(HV, 12'h032, 4'd1, 64'h20);
        check("R10 setup hv notify", {63'd0, irq}, 64'd1);
        ld(HV, 12'h830, 4'd4, d); check("R10 wrong size returns 0", d, 64'd0);
        check("R10 wrong size keeps irq", {63'd0, irq}, 64'd1);
        ld(OS, 12'h830, 4'd2, d); check("R10 wrong page returns 0", d, 64'd0);
        st(HV, 12'h830, 4'd2, 64'hFFFF);
        check("R10 store to ack keeps irq", {63'd0, irq}, 64'd1);
        ld(HV, 12'h030, 4'd1, d); check("R10 status untouched", d, 64'h40);
        ld(HV, 12'h031, 4'd1, d); check("R10 cppr untouched", d, 64'd7);
        ld(HV, 12'h830, 4'd2, d); check("R5 hv ack word", d, 64'h4007);
        check("R5 hv ack lowers irq", {63'd0, irq}, 64'd0);

        // R6 / R11 / R12: pool word store, pull and clear
        st(OS, 12'h028, 4'd4, 64'hDEADBEEF);
        ld(HV, 12'h028, 4'd4, d); check("R11 os page pool store dropped", d, 64'd0);
        st(HV, 12'h028, 4'd4, 64'hDEADBEEF);
        ld(HV, 12'h028, 4'd4, d); check("R12 pool word load", d, 64'hDEADBEEF);
        ld(OS, 12'h838, 4'd4, d); check("R10 pull on os page returns 0", d, 64'd0);
        ld(HV, 12'h028, 4'd4, d); check("R10 pull on os page no effect", d, 64'hDEADBEEF);
        ld(HV, 12'h838, 4'd4, d); check("R6 pull 4-byte value", d, 64'h1EADBEEF);
        ld(HV, 12'h028, 4'd4, d); check("R6 pull keeps top bits", d, 64'hC0000000);
        ld(HV, 12'h838, 4'd8, d); check("R6 second pull empty", d, 64'd0);
        st(HV, 12'h028, 4'd4, 64'h12345678);
        ld(HV, 12'h838, 4'd8, d); check("R6 pull 8-byte value", d, 64'h12345678);
        ld(HV, 12'h028, 4'd4, d); check("R6 8-byte pull clears", d, 64'd0);

        // R7 / R11: context byte push and poll
        st(HV, 12'h038, 4'd1, 64'hA5C3);
        ld(HV, 12'h038, 4'd1, d); check("R7 poll after push", d, 64'hC3);
        st(OS, 12'h038, 4'd1, 64'h11);
        ld(HV, 12'h038, 4'd1, d); check("R11 os page push dropped", d, 64'hC3);
        ld(OS, 12'h038, 4'd1, d); check("R12 plain byte load of context", d, 64'hC3);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule